// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block holds a group of participants at a shared synchronization point until every one of them has reached it, then lets them all proceed together. Each participant signals arrival with a one-cycle pulse on its own arrive line. It then watches its own done line, which rises once the whole group has arrived. The block keeps a shared arrival count, one shared release flag, and a private phase bit for each participant.

A participant flips its private phase bit when it arrives. The participant whose arrival brings the count to the group size returns the count to zero and copies its new phase into the release flag. Nothing ever clears the flag at the start of a barrier. The value that releases the group therefore alternates from one barrier to the next. A fast participant that re-enters the next barrier right after a release cannot withdraw that release from the slower ones.

Arrivals in the same cycle are summed. The arrival that fills the count acts as the final arriver, so several participants, or the whole group, may complete a barrier in one cycle.

Top module: `sense_barrier_unit`

## Requirements
- R1: After reset the arrival count is 0, the release flag (`release_flag_o`) is 0, every private phase bit is 0 and every `done_o` bit is 0.
- R2: An accepted arrival inverts that participant's private phase bit. An arrival is accepted unless the participant has arrived and its phase bit differs from the release flag.
- R3: In each cycle the arrival count grows by the number of accepted arrivals in that cycle, and it never exceeds the group size `N_PART`.
- R4: While fewer than `N_PART` participants have arrived at the current barrier, the `done_o` bit of every participant waiting in it stays 0.
- R5: The cycle after the arrival that brings the count to `N_PART`, the count is 0, the release flag holds the new phase, and all `done_o` bits are 1.
- R6: The release flag is never cleared when a barrier begins. It changes only on completion, so its value after successive barriers is 1, 0, 1, 0, ...
- R7: `done_o[i]` is 1 while participant i has arrived and its phase bit equals the release flag. It drops the cycle after that participant's next accepted arrival, and the `done_o` bits of the other participants are not affected.
- R8: An arrive pulse from a participant that is still waiting in the current barrier is ignored: it neither changes the count nor completes the barrier early.
- R9: If all `N_PART` participants arrive in the same cycle, the barrier completes in that cycle and all `done_o` bits are 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_PART | One-cycle arrival pulse, one bit per participant |
| done_o | output | N_PART | Release status, one bit per participant |
| release_flag_o | output | 1 | Current value of the shared release flag |

## Verification
The hardest case to reach is a participant re-entering the next barrier while the others are still sitting in their released state, followed by a second, ignored pulse from that same participant while it waits. The bench completes one barrier, then pulses a single participant at once, and checks that the others keep `done_o` high. It then pulses the same participant again and checks that the next barrier does not complete until every other participant has arrived. An ignored pulse that was wrongly counted would show up as an early completion.

// File: rtl/sbar_pkg.sv
package sbar_pkg;
   // Width needed to hold values 0..n inclusive.
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/sbar_lane.sv
module sbar_lane (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arrive_i,
   input  logic flag_i,
   output logic accept_o,
   output logic sense_o,
   output logic done_o
);
   logic sense_q;
   logic entered_q;
   logic waiting;

   // A participant waits while its phase differs from the published flag.
   assign waiting  = entered_q & (sense_q != flag_i);
   assign accept_o = arrive_i & ~waiting;
   assign done_o   = entered_q & (sense_q == flag_i);
   assign sense_o  = sense_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sense_q   <= 1'b0;
         entered_q <= 1'b0;
      end else if (accept_o) begin
         sense_q   <= ~sense_q;
         entered_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sbar_popcount.sv
module sbar_popcount #(
   parameter int N_BITS    = 4,
   parameter int OUT_W     = 3,
   parameter bit USE_CHAIN = 1'b0
) (
   input  logic [N_BITS-1:0] vec_i,
   output logic [OUT_W-1:0]  sum_o
);
   if (OUT_W < $clog2(N_BITS + 1)) begin : g_bad_width
      $error("sbar_popcount: OUT_W too narrow for N_BITS");
   end

   if (USE_CHAIN) begin : g_chain
      // Linear ripple accumulation: smallest area, deepest path.
      always_comb begin
         sum_o = '0;
         for (int k = 0; k < N_BITS; k++) begin
            sum_o = sum_o + OUT_W'(vec_i[k]);
         end
      end
   end else begin : g_builtin
      // Leave tree shaping to the synthesis tool.
      assign sum_o = OUT_W'($countones(vec_i));
   end
endmodule

// File: rtl/sbar_counter.sv
module sbar_counter #(
   parameter int N_PART = 4,
   parameter int CW     = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW:0]   add_i,
   output logic [CW-1:0] cnt_o,
   output logic          flag_o,
   output logic          complete_o
);
   localparam logic [CW:0] TARGET = (CW + 1)'(N_PART);

   logic [CW-1:0] cnt_q;
   logic          flag_q;
   logic [CW:0]   next_sum;

   assign next_sum   = {1'b0, cnt_q} + add_i;
   assign complete_o = (add_i != '0) && (next_sum == TARGET);
   assign cnt_o      = cnt_q;
   assign flag_o     = flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (complete_o) begin
         // Final arriver: clear count, publish its new phase (inverse of flag).
         cnt_q  <= '0;
         flag_q <= ~flag_q;
      end else begin
         cnt_q  <= next_sum[CW-1:0];
      end
   end
endmodule

// File: rtl/sense_barrier_unit.sv
module sense_barrier_unit #(
   parameter int N_PART    = 4,
   parameter bit USE_CHAIN = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_PART-1:0] arrive_i,
   output logic [N_PART-1:0] done_o,
   output logic              release_flag_o
);
   localparam int CW = sbar_pkg::cnt_width(N_PART);

   if (N_PART < 2) begin : g_bad_parts
      $error("sense_barrier_unit: N_PART must be at least 2");
   end

   logic [N_PART-1:0] accept_w;
   logic [N_PART-1:0] sense_w;
   logic [CW:0]       add_w;
   logic [CW-1:0]     cnt_w;
   logic              flag_w;
   logic              complete_w;

   for (genvar i = 0; i < N_PART; i++) begin : g_lane
      sbar_lane u_lane (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .arrive_i (arrive_i[i]),
         .flag_i   (flag_w),
         .accept_o (accept_w[i]),
         .sense_o  (sense_w[i]),
         .done_o   (done_o[i])
      );
   end

   sbar_popcount #(.N_BITS(N_PART), .OUT_W(CW + 1), .USE_CHAIN(USE_CHAIN)) u_pop (
      .vec_i (accept_w),
      .sum_o (add_w)
   );

   sbar_counter #(.N_PART(N_PART), .CW(CW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .add_i      (add_w),
      .cnt_o      (cnt_w),
      .flag_o     (flag_w),
      .complete_o (complete_w)
   );

   assign release_flag_o = flag_w;
endmodule

// File: rtl/sbar_checker.sv
module sbar_checker #(
   parameter int N_PART = 4,
   parameter int CW     = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [N_PART-1:0] arrive_i,
   input logic [N_PART-1:0] accept_w,
   input logic [N_PART-1:0] sense_w,
   input logic [N_PART-1:0] done_o,
   input logic [CW-1:0]     cnt_w,
   input logic              flag_w,
   input logic              complete_w
);
   p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_w <= CW'(N_PART));

   p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      complete_w |=> (cnt_w == '0) && (flag_w != $past(flag_w)));

   p_all_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      complete_w |=> (&done_o));

   p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !complete_w |=> $stable(flag_w));

   for (genvar i = 0; i < N_PART; i++) begin : g_lane_chk
      p_sense_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         accept_w[i] |=> (sense_w[i] != $past(sense_w[i])));

      p_wait_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (arrive_i[i] && !done_o[i] && (sense_w[i] != flag_w)) |=> $stable(sense_w[i]));

      p_done_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (accept_w[i] && !complete_w) |=> !done_o[i]);
   end
endmodule

bind sense_barrier_unit sbar_checker #(.N_PART(N_PART), .CW(CW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .arrive_i   (arrive_i),
   .accept_w   (accept_w),
   .sense_w    (sense_w),
   .done_o     (done_o),
   .cnt_w      (cnt_w),
   .flag_w     (flag_w),
   .complete_w (complete_w)
);

// File: tb/sim_sense_barrier_unit.sv
`timescale 1ns/1ps
module sim_sense_barrier_unit;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] arrive = '0;
   logic [NP-1:0] done;
   logic          flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   sense_barrier_unit #(.N_PART(NP)) u0 (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .arrive_i       (arrive),
      .done_o         (done),
      .release_flag_o (flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive a mask for one cycle; return sampled at the negedge after the edge.
   task automatic pulse(input logic [NP-1:0] m);
      @(negedge clk);
      arrive = m;
      @(negedge clk);
      arrive = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 done", 32'(done), 32'h0);
      check("R1 flag", 32'(flag), 32'h0);
   endtask

   task automatic t_partial();
      pulse(4'b0001);
      check("R4 after 1", 32'(done), 32'h0);
      pulse(4'b0010);
      check("R4 after 2", 32'(done), 32'h0);
      pulse(4'b0100);
      check("R4 after 3", 32'(done), 32'h0);
      pulse(4'b1000);
      check("R5 all done", 32'(done), 32'hF);
      check("R6 flag first", 32'(flag), 32'h1);
   endtask

   task automatic t_early_reentry();
      pulse(4'b0001);
      check("R7 others kept", 32'(done), 32'hE);
      check("R6 flag kept", 32'(flag), 32'h1);
      pulse(4'b0001); // still waiting: ignored
      check("R8 ignored", 32'(done), 32'hE);
      pulse(4'b0110);
      check("R8 no early release", 32'(done), 32'h8);
      check("R3 flag unchanged", 32'(flag), 32'h1);
      pulse(4'b1000);
      check("R5 second release", 32'(done), 32'hF);
      check("R6 flag second", 32'(flag), 32'h0);
   endtask

   task automatic t_all_same_cycle();
      pulse(4'b1111);
      check("R9 all at once", 32'(done), 32'hF);
      check("R9 flag", 32'(flag), 32'h1);
   endtask

   task automatic t_grouped();
      pulse(4'b0011);
      check("R3 two arrived", 32'(done), 32'hC);
      pulse(4'b1100);
      check("R3 group completes", 32'(done), 32'hF);
      check("R6 flag grouped", 32'(flag), 32'h0);
   endtask

   task automatic t_alternation();
      for (int k = 0; k < 4; k++) begin
         pulse(4'b1111);
         check("R6 alternation", 32'(flag), 32'((k % 2) == 0));
         check("R5 done loop", 32'(done), 32'hF);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_partial();
      t_early_reentry();
      t_all_same_cycle();
      t_grouped();
      t_alternation();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule